// File: doc/BRIEF.md
# Multidrop UART Receive Address Filter

This block sits behind the bit-level receiver of a slave node on a shared 9-bit serial bus. Each time the receiver finishes a frame it pulses a strobe and presents the data byte, the ninth bit and the sampled stop bit. The filter captures these values and evaluates the frame one cycle later. It raises a sticky receive-interrupt request only for frames that the node should handle. In the two 9-bit modes, with the multiprocessor enable set, only address frames (ninth bit 1) addressed to this node get through. A frame is addressed to the node when it matches either the masked "directed" address or the OR-derived "broadcast" address. A single node can therefore answer to a unique address, to a group address, and to an all-call address.

The block also keeps a sticky framing-error flag. That flag shares one control-register bit position with the high mode bit. A select input decides which of the two that position shows and which of the two it writes. The ninth bit of each accepted frame is kept in a readable register.

The controller has two states:
- `S_IDLE` waits for the frame strobe and captures the frame. This is the transition *capture*.
- `S_EVAL` decides acceptance and then always returns to `S_IDLE`. This is the transition *retire*.

A strobe that arrives while the controller is in `S_EVAL` is not taken.

Top module: `uart_addr_filter`

## Requirements
- R1: `dir_match` is 1 exactly when the last captured byte equals `slave_addr` in every bit position where `addr_mask` is 1. Positions where the mask is 0 are don't-care.
- R2: `bcast_match` is 1 exactly when the last captured byte has a 1 in every position where `slave_addr | addr_mask` is 1.
- R3: When the mode is 2 or 3 (`ctl_mode_hi`=1) and `mp_en`=1, a frame raises `ri` only if all of the following hold: `rx_en`=1, the ninth bit is 1, and R1 or R2 matches.
- R4: When `mp_en`=0, every frame received with `rx_en`=1 raises `ri`. With `rx_en`=0 no frame raises `ri`.
- R5: In modes 0 and 1 (`ctl_mode_hi`=0), `mp_en` has no effect on acceptance.
- R6: With `slave_addr` and `addr_mask` both 0, every byte gives `dir_match`=1 and `bcast_match`=1.
- R7: `fe_flag` is set when a frame received with `rx_en`=1 has a stop bit of 0. It stays set until a write with `fe_sel`=1 and `ctl_wdata`=0. A hardware set wins over a write in the same cycle.
- R8: `ctl_view` shows `fe_flag` when `fe_sel`=1 and `ctl_mode_hi` when `fe_sel`=0. A write (`ctl_wr`=1) updates only the selected one of the two.
- R9: `rb8` takes the ninth bit of each accepted frame and holds its value across rejected frames.
- R10: `ri` becomes 1 at the second rising edge after the strobe edge of an accepted frame. It holds until `ri_clr`, and a set wins over a clear in the same cycle.
- R11: With slave address 8'hC0 and mask 8'hFD, in mode 2 with `mp_en`=1, address frames 8'hC0 and 8'hC2 are accepted and 8'hC1 is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_done | input | 1 | One-cycle pulse: a frame is complete |
| rx_byte | input | 8 | Received data byte |
| rx_bit9 | input | 1 | Received ninth bit |
| rx_stop | input | 1 | Sampled stop bit |
| mode_lo | input | 1 | Low mode bit |
| mp_en | input | 1 | Multiprocessor filter enable |
| rx_en | input | 1 | Receive enable |
| slave_addr | input | 8 | Slave address |
| addr_mask | input | 8 | Address mask |
| fe_sel | input | 1 | 1: shared bit is the framing-error flag; 0: shared bit is the high mode bit |
| ctl_wr | input | 1 | Write strobe for the shared bit |
| ctl_wdata | input | 1 | Write data for the shared bit |
| ri_clr | input | 1 | Clears the receive interrupt |
| ri | output | 1 | Receive-interrupt request |
| rb8 | output | 1 | Ninth bit of the last accepted frame |
| fe_flag | output | 1 | Framing-error flag |
| ctl_mode_hi | output | 1 | High mode bit |
| ctl_view | output | 1 | Value shown at the shared bit position |
| dir_match | output | 1 | Directed-address match for the captured byte |
| bcast_match | output | 1 | Broadcast-address match for the captured byte |

## Verification
The match outputs are due one edge after the strobe edge. They are derived from the captured byte and hold until the next capture. `ri`, `rb8` and `fe_flag` are due at the second edge after the strobe edge. Shared-bit writes show on `ctl_view` one edge after the write. The bench drives every input on the falling edge. It samples the match outputs at the falling edge after the capture edge, and samples `ri`, `rb8` and `fe_flag` one falling edge later. This places every comparison half a cycle clear of the edge at which the value settles.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
    localparam int unsigned ADDR_W = 8;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_EVAL = 1'b1
    } uaf_state_e;
endpackage

// File: rtl/uaf_match.sv
module uaf_match #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_byte,
    input  logic [W-1:0] slave_addr,
    input  logic [W-1:0] addr_mask,
    output logic         dir_match,
    output logic         bcast_match
);
    logic [W-1:0] bcast_addr;
    logic [W-1:0] diff_bits;

    always_comb begin
        bcast_addr  = slave_addr | addr_mask;
        diff_bits   = (cap_byte ^ slave_addr) & addr_mask;
        dir_match   = (diff_bits == '0);
        bcast_match = ((cap_byte & bcast_addr) == bcast_addr);
    end

    // R6: cleared address registers leave every byte matching
    a_r6_open_match: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_addr == '0 && addr_mask == '0) |-> (dir_match && bcast_match));
    // R2: an all-ones byte always meets the broadcast address
    a_r2_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_byte == '1) |-> bcast_match);
endmodule

// File: rtl/uaf_ctl.sv
module uaf_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fe_set,
    input  logic fe_sel,
    input  logic ctl_wr,
    input  logic ctl_wdata,
    output logic fe_flag,
    output logic mode_hi,
    output logic ctl_view
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_flag <= 1'b0;
            mode_hi <= 1'b0;
        end else begin
            if (fe_set)
                fe_flag <= 1'b1;
            else if (ctl_wr && fe_sel)
                fe_flag <= ctl_wdata;
            if (ctl_wr && !fe_sel)
                mode_hi <= ctl_wdata;
        end
    end

    always_comb ctl_view = fe_sel ? fe_flag : mode_hi;

    // R8: the mode bit moves only on a write that selects it
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && !fe_sel) |=> $stable(mode_hi));
    // R7: the flag rises only from a bad stop bit or an explicit write of 1
    a_r7_fe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_flag) |-> $past(fe_set || (ctl_wr && fe_sel && ctl_wdata)));
    // R7: a hardware set always leaves the flag high
    a_r7_fe_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fe_set |=> fe_flag);
endmodule

// File: rtl/uaf_fsm.sv
module uaf_fsm
    import uaf_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_done,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_bit9,
    input  logic         rx_stop,
    input  logic         rx_en,
    input  logic         mp_en,
    input  logic         mode_hi,
    input  logic         ri_clr,
    input  logic         dir_match,
    input  logic         bcast_match,
    output logic [W-1:0] cap_byte,
    output logic         ri,
    output logic         rb8,
    output logic         fe_set
);
    uaf_state_e st_q, st_nx;
    logic       cap_bit9;
    logic       cap_stop;
    logic       filt_on;
    logic       accept;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE: st_nx = frm_done ? S_EVAL : S_IDLE;
            S_EVAL: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        filt_on = mode_hi && mp_en;
        accept  = (st_q == S_EVAL) && rx_en &&
                  (!filt_on || (cap_bit9 && (dir_match || bcast_match)));
        fe_set  = (st_q == S_EVAL) && rx_en && !cap_stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_byte <= '0;
            cap_bit9 <= 1'b0;
            cap_stop <= 1'b1;
            ri       <= 1'b0;
            rb8      <= 1'b0;
        end else begin
            if (st_q == S_IDLE && frm_done) begin
                cap_byte <= rx_byte;
                cap_bit9 <= rx_bit9;
                cap_stop <= rx_stop;
            end
            if (accept) begin
                ri  <= 1'b1;
                rb8 <= cap_bit9;
            end else if (ri_clr) begin
                ri <= 1'b0;
            end
        end
    end

    // R10: evaluation lasts exactly one cycle
    a_r10_eval_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EVAL) |=> (st_q == S_IDLE));
    // R10: the interrupt rises only out of an evaluation cycle
    a_r10_ri_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri) |-> $past(st_q == S_EVAL));
    // R9: the ninth-bit register changes only on an acceptance
    a_r9_rb8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(rb8));
    // R3: with filtering active, a data frame is never taken
    a_r3_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_EVAL) && filt_on && !cap_bit9 && !ri_clr) |=> (ri == $past(ri)));
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
    import uaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_done,
    input  logic [ADDR_W-1:0] rx_byte,
    input  logic              rx_bit9,
    input  logic              rx_stop,
    input  logic              mode_lo,
    input  logic              mp_en,
    input  logic              rx_en,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              fe_sel,
    input  logic              ctl_wr,
    input  logic              ctl_wdata,
    input  logic              ri_clr,
    output logic              ri,
    output logic              rb8,
    output logic              fe_flag,
    output logic              ctl_mode_hi,
    output logic              ctl_view,
    output logic              dir_match,
    output logic              bcast_match
);
    logic [ADDR_W-1:0] cap_byte;
    logic              fe_set;
    logic              mode_lo_unused;

    // the low mode bit does not change filtering: modes 0/1 and 2/3 behave alike
    always_comb mode_lo_unused = mode_lo;

    uaf_match #(.W(ADDR_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_byte    (cap_byte),
        .slave_addr  (slave_addr),
        .addr_mask   (addr_mask),
        .dir_match   (dir_match),
        .bcast_match (bcast_match)
    );

    uaf_fsm #(.W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_done    (frm_done),
        .rx_byte     (rx_byte),
        .rx_bit9     (rx_bit9),
        .rx_stop     (rx_stop),
        .rx_en       (rx_en),
        .mp_en       (mp_en),
        .mode_hi     (ctl_mode_hi),
        .ri_clr      (ri_clr),
        .dir_match   (dir_match),
        .bcast_match (bcast_match),
        .cap_byte    (cap_byte),
        .ri          (ri),
        .rb8         (rb8),
        .fe_set      (fe_set)
    );

    uaf_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fe_set    (fe_set),
        .fe_sel    (fe_sel),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .fe_flag   (fe_flag),
        .mode_hi   (ctl_mode_hi),
        .ctl_view  (ctl_view)
    );

    // R5: in modes 0/1 every enabled frame is taken whatever mp_en says
    a_r5_mp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (u_fsm.st_q == S_EVAL && !ctl_mode_hi && rx_en) |=> ri);
endmodule

// File: tb/tb_uart_addr_filter.sv
module tb_uart_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_bit9 = 1'b0;
    logic       rx_stop = 1'b1;
    logic       mode_lo = 1'b0;
    logic       mp_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [7:0] slave_addr = '0;
    logic [7:0] addr_mask = '0;
    logic       fe_sel = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_wdata = 1'b0;
    logic       ri_clr = 1'b0;
    logic ri, rb8, fe_flag, ctl_mode_hi, ctl_view, dir_match, bcast_match;

    int checks = 0;
    int errors = 0;
    logic exp_rb8 = 1'b0;
    logic exp_fe = 1'b0;
    logic exp_mhi = 1'b0;

    always #5 clk = ~clk;

    uart_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .rx_byte(rx_byte),
        .rx_bit9(rx_bit9), .rx_stop(rx_stop), .mode_lo(mode_lo), .mp_en(mp_en),
        .rx_en(rx_en), .slave_addr(slave_addr), .addr_mask(addr_mask),
        .fe_sel(fe_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ri_clr(ri_clr),
        .ri(ri), .rb8(rb8), .fe_flag(fe_flag), .ctl_mode_hi(ctl_mode_hi),
        .ctl_view(ctl_view), .dir_match(dir_match), .bcast_match(bcast_match)
    );

    function automatic logic f_dir(logic [7:0] b, logic [7:0] sa, logic [7:0] mk);
        for (int i = 0; i < 8; i++)
            if (mk[i] && (b[i] != sa[i])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic f_bc(logic [7:0] b, logic [7:0] sa, logic [7:0] mk);
        for (int i = 0; i < 8; i++)
            if ((sa[i] || mk[i]) && !b[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic f_acc(logic [7:0] b, logic b9, logic mhi, logic mp,
                                   logic ren, logic [7:0] sa, logic [7:0] mk);
        if (!ren) return 1'b0;
        if (!(mhi && mp)) return 1'b1;
        return b9 && (f_dir(b, sa, mk) || f_bc(b, sa, mk));
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic clear_ri();
        @(negedge clk); ri_clr = 1'b1;
        @(negedge clk); ri_clr = 1'b0;
    endtask

    task automatic write_shared(logic sel, logic v);
        @(negedge clk); fe_sel = sel; ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
        if (sel) exp_fe = v; else exp_mhi = v;
    endtask

    // drive a frame; match outputs checked one falling edge later, results one more
    task automatic frame(string req, logic [7:0] b, logic b9, logic stp);
        logic acc;
        clear_ri();
        acc = f_acc(b, b9, exp_mhi, mp_en, rx_en, slave_addr, addr_mask);
        @(negedge clk);
        frm_done = 1'b1; rx_byte = b; rx_bit9 = b9; rx_stop = stp;
        @(negedge clk);
        frm_done = 1'b0;
        check({req, " R1 dir"}, dir_match, f_dir(b, slave_addr, addr_mask));
        check({req, " R2 bcast"}, bcast_match, f_bc(b, slave_addr, addr_mask));
        @(negedge clk);
        if (acc) exp_rb8 = b9;
        if (rx_en && !stp) exp_fe = 1'b1;
        check({req, " R10 ri"}, ri, acc);
        check({req, " R9 rb8"}, rb8, exp_rb8);
        check({req, " R7 fe"}, fe_flag, exp_fe);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // reset state
        check("R7 reset fe", fe_flag, 1'b0);
        check("R10 reset ri", ri, 1'b0);
        check("R9 reset rb8", rb8, 1'b0);
        check("R8 reset view", ctl_view, 1'b0);
        rst_n = 1'b1;
        rx_en = 1'b1;

        // R6: cleared registers match everything, plain receiver
        write_shared(1'b0, 1'b1);
        check("R8 mode view", ctl_view, 1'b1);
        check("R8 mode out", ctl_mode_hi, 1'b1);
        mp_en = 1'b1;
        frame("R6 open", 8'h5A, 1'b1, 1'b1);
        frame("R6 open ff", 8'h00, 1'b1, 1'b1);

        // R11 test vector, mode 2
        slave_addr = 8'hC0; addr_mask = 8'hFD;
        frame("R11 C0", 8'hC0, 1'b1, 1'b1);
        frame("R11 C2", 8'hC2, 1'b1, 1'b1);
        frame("R11 C1", 8'hC1, 1'b1, 1'b1);
        frame("R2 bcast FF", 8'hFF, 1'b1, 1'b1);
        frame("R3 data bit9 0", 8'hC0, 1'b0, 1'b1);
        // R4: filter off, data frames accepted; rx_en off rejects
        mp_en = 1'b0;
        frame("R4 mp off", 8'h11, 1'b0, 1'b1);
        rx_en = 1'b0;
        frame("R4 rx off", 8'hC0, 1'b1, 1'b0);
        rx_en = 1'b1;
        // R5: mode 0 ignores mp_en
        mp_en = 1'b1;
        write_shared(1'b0, 1'b0);
        check("R8 mode cleared", ctl_mode_hi, 1'b0);
        frame("R5 mode0", 8'h33, 1'b0, 1'b1);
        mode_lo = 1'b1;
        frame("R5 mode1", 8'h34, 1'b1, 1'b1);
        // R7 framing error, sticky, shared bit view
        frame("R7 bad stop", 8'h01, 1'b0, 1'b0);
        frame("R7 sticky", 8'h02, 1'b0, 1'b1);
        @(negedge clk); fe_sel = 1'b1; #1;
        check("R8 view fe", ctl_view, 1'b1);
        check("R8 mode unaffected", ctl_mode_hi, 1'b0);
        write_shared(1'b1, 1'b0);
        check("R7 cleared", fe_flag, 1'b0);
        check("R8 mode kept", ctl_mode_hi, 1'b0);
        // R10: ri holds without clear
        repeat (4) @(negedge clk);
        check("R10 ri hold", ri, 1'b1);

        // random mix
        for (int n = 0; n < 300; n++) begin
            if ($urandom % 8 == 0) write_shared(1'b0, 1'($urandom));
            if ($urandom % 6 == 0) write_shared(1'b1, 1'b0);
            mp_en = 1'($urandom); mode_lo = 1'($urandom);
            rx_en = ($urandom % 6) != 0;
            if ($urandom % 10 == 0) begin
                slave_addr = 8'($urandom); addr_mask = 8'($urandom);
            end
            frame("R3 rand", ($urandom % 3 == 0) ? (slave_addr & addr_mask) : 8'($urandom),
                  1'($urandom), ($urandom % 7) != 0);
        end
        finish_run();
    end
endmodule